// File: doc/BRIEF.md
# Two-Port Three-Bank Read Arbiter

This block sits between two host read ports and three independent flash bank paths. Each host port presents a level request and an address. The block decodes the address into one of three banks, or into an unmapped region, and passes the access to that bank's path with a bank-relative offset. When the bank finishes, the block routes the completion and the read data back to the port that owns the access.

Requests from the two ports that land in different banks are granted in the same cycle and run side by side. Requests that land in the same bank are ordered by a small arbiter that belongs to that bank, so contention in one bank never stalls traffic to another. A configuration input selects the policy per decision: fixed priority, where port 0 wins, or round-robin, which uses a last-granted pointer per bank. Once a grant is made, it stays with its port until the bank reports completion. The port that lost waits in the meantime.

A host keeps its request and address stable from the cycle it raises the request through the cycle it sees completion. It may drop the request, or present a new one, from the next cycle on. A bank path keeps its completion input low while it has no request.

Top module: `flashBankArb`

## Requirements
- R1: The address map is contiguous from zero. Bank 0 covers [0x000000, 0x400000). Bank 1 covers [0x400000, 0xC00000). Bank 2 covers [0xC00000, 0x1000000). The bank address is the host address minus the base of its bank.
- R2: Requests from the two ports to different banks both drive their bank request in the cycle they are raised. Neither port sees wait, and each completes in the same cycle as its own bank.
- R3: When both ports request the same idle bank in the same cycle, exactly one is granted. The other sees wait asserted until it is granted.
- R4: With the policy input low (fixed priority), port 0 wins every same-bank conflict.
- R5: With the policy input high (round-robin), each bank keeps its own last-granted port. A conflict at a bank goes to the port not granted most recently at that bank. After reset every bank treats port 1 as last granted.
- R6: A grant holds until the bank signals completion. The bank request stays high and the bank address stays stable in between, even if the other port requests the same bank.
- R7: Bank completion raises completion on the owning port only, in the same cycle, with that bank's read data. The completion releases the bank, and it is re-arbitrated from the next cycle.
- R8: A request at or above 0x1000000 gets completion and error in the same cycle with zero data, and no bank request.
- R9: A change of the policy input never moves a grant already in progress. It applies from the next arbitration decision on.
- R10: Out of reset there are no bank requests, no wait, no completion and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| roundRobin | input | 1 | Policy select: 0 fixed priority, 1 round-robin |
| hostReq | input | 2 | Per-port read request, held until completion |
| hostAddr | input | 2 x ADDR_W | Per-port byte address |
| hostWait | output | 2 | Port is requesting but not yet granted |
| hostDone | output | 2 | Per-port completion strobe |
| hostErr | output | 2 | Completion is an unmapped-address error |
| hostRdata | output | 2 x DATA_W | Read data, valid with completion |
| bankReq | output | 3 | Per-bank access request |
| bankAddr | output | 3 x ADDR_W | Bank-relative address of the granted port |
| bankDone | input | 3 | Per-bank access completion |
| bankRdata | input | 3 x DATA_W | Per-bank read data |

## Verification
The assertions check several rules on every cycle. A held grant keeps its bank request and address stable until completion. Wait, error and completion appear only with a request behind them. Completions never exceed the bank completions. Granted ports never outnumber active banks. Which port wins a conflict under each policy, how the round-robin pointer stays local to each bank, the exact completion cycles of a winner and a loser, the decode boundaries, and the policy change during a grant are only visible in the bench's directed scenarios. In those scenarios a bank model with set latency returns data that encodes the bank and offset, and a scoreboard compares that data with expectations from the address map.

// File: rtl/arbPkg.sv
package arbPkg;
  localparam int NPORT = 2;
  localparam int NBANK = 3;
  localparam int SEL_W = $clog2(NBANK);

  typedef logic [SEL_W-1:0] bankSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NBANK-1:0]           bankIssue;
    logic [NBANK-1:0]           bankOwner;
    logic [NPORT-1:0]           portGrant;
    bankSel_t [NPORT-1:0]       portSel;
  } strobe_t;
endpackage

// File: rtl/addrDecode.sv
module addrDecode
  import arbPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LOG0   = 22,
  parameter int LOG1   = 23,
  parameter int LOG2   = 22
) (
  input  logic [ADDR_W-1:0] addr,
  output bankSel_t          sel,
  output logic              inRange,
  output logic [ADDR_W-1:0] offset
);
  localparam int EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] LIM0 = EXT_W'(1) << LOG0;
  localparam logic [EXT_W-1:0] LIM1 = LIM0 + (EXT_W'(1) << LOG1);
  localparam logic [EXT_W-1:0] LIM2 = LIM1 + (EXT_W'(1) << LOG2);
  localparam logic [ADDR_W-1:0] BASE1 = LIM0[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] BASE2 = LIM1[ADDR_W-1:0];

  logic [EXT_W-1:0]  ext;
  logic [ADDR_W-1:0] base;

  always_comb begin
    ext     = {1'b0, addr};
    sel     = '0;
    inRange = 1'b1;
    base    = '0;
    if (ext < LIM0) begin
      sel = bankSel_t'(0);
    end else if (ext < LIM1) begin
      sel  = bankSel_t'(1);
      base = BASE1;
    end else if (ext < LIM2) begin
      sel  = bankSel_t'(2);
      base = BASE2;
    end else begin
      inRange = 1'b0;
    end
    offset = inRange ? (addr - base) : '0;
  end
endmodule

// File: rtl/bankArb.sv
module bankArb
  import arbPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPORT-1:0] want,
  input  logic             roundRobin,
  input  logic             done,
  output logic             issue,
  output logic             owner
);
  logic busyQ, ownerQ, lastQ, winner;

  always_comb begin
    if (&want) winner = roundRobin ? ~lastQ : 1'b0;
    else       winner = want[1];
    issue = busyQ | (|want);
    owner = busyQ ? ownerQ : winner;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      ownerQ <= 1'b0;
      lastQ  <= 1'b1;
    end else if (busyQ) begin
      if (done) busyQ <= 1'b0;
    end else if (|want) begin
      lastQ  <= winner;
      ownerQ <= winner;
      busyQ  <= ~done;
    end
  end
endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  roundRobin,
  input  logic [NPORT-1:0]      hostReq,
  input  bankSel_t [NPORT-1:0]  portSel,
  input  logic [NPORT-1:0]      portInRange,
  input  logic [NBANK-1:0]      bankDone,
  output strobe_t               strobe,
  output logic [NPORT-1:0]      hostWait,
  output logic [NPORT-1:0]      hostDone,
  output logic [NPORT-1:0]      hostErr
);
  logic [NBANK-1:0][NPORT-1:0] want;
  logic [NBANK-1:0]            issue;
  logic [NBANK-1:0]            owner;
  logic [NPORT-1:0]            grant;
  logic [NPORT-1:0]            finish;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      for (int p = 0; p < NPORT; p++)
        want[b][p] = hostReq[p] & portInRange[p] & (portSel[p] == bankSel_t'(b));
  end

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    bankArb u_arb (
      .clk       (clk),
      .rstN      (rstN),
      .want      (want[gb]),
      .roundRobin(roundRobin),
      .done      (bankDone[gb]),
      .issue     (issue[gb]),
      .owner     (owner[gb])
    );
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      grant[p]  = 1'b0;
      finish[p] = 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        if (want[b][p] && issue[b] && (owner[b] == p[0])) begin
          grant[p]  = 1'b1;
          finish[p] = bankDone[b];
        end
      end
      hostWait[p] = hostReq[p] & portInRange[p] & ~grant[p];
      hostErr[p]  = hostReq[p] & ~portInRange[p];
      hostDone[p] = finish[p] | hostErr[p];
    end
    strobe.bankIssue = issue;
    strobe.bankOwner = owner;
    strobe.portGrant = grant;
    strobe.portSel   = portSel;
  end
endmodule

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  strobe_t                         strobe,
  input  logic [NPORT-1:0][ADDR_W-1:0]    portOffset,
  input  logic [NBANK-1:0]                bankDone,
  input  logic [NBANK-1:0][DATA_W-1:0]    bankRdata,
  output logic [NBANK-1:0]                bankReq,
  output logic [NBANK-1:0][ADDR_W-1:0]    bankAddr,
  output logic [NPORT-1:0][DATA_W-1:0]    hostRdata
);
  always_comb begin
    bankReq = strobe.bankIssue;
    for (int b = 0; b < NBANK; b++)
      bankAddr[b] = strobe.bankIssue[b] ? portOffset[strobe.bankOwner[b]] : '0;
    for (int p = 0; p < NPORT; p++) begin
      hostRdata[p] = '0;
      for (int b = 0; b < NBANK; b++)
        if (strobe.portGrant[p] && strobe.portSel[p] == bankSel_t'(b) && bankDone[b])
          hostRdata[p] = bankRdata[b];
    end
  end
endmodule

// File: rtl/flashBankArb.sv
module flashBankArb
  import arbPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int LOG0   = 22,
  parameter int LOG1   = 23,
  parameter int LOG2   = 22
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          roundRobin,
  input  logic [NPORT-1:0]              hostReq,
  input  logic [NPORT-1:0][ADDR_W-1:0]  hostAddr,
  output logic [NPORT-1:0]              hostWait,
  output logic [NPORT-1:0]              hostDone,
  output logic [NPORT-1:0]              hostErr,
  output logic [NPORT-1:0][DATA_W-1:0]  hostRdata,
  output logic [NBANK-1:0]              bankReq,
  output logic [NBANK-1:0][ADDR_W-1:0]  bankAddr,
  input  logic [NBANK-1:0]              bankDone,
  input  logic [NBANK-1:0][DATA_W-1:0]  bankRdata
);
  bankSel_t [NPORT-1:0]         portSel;
  logic [NPORT-1:0]             portInRange;
  logic [NPORT-1:0][ADDR_W-1:0] portOffset;
  strobe_t                      strobe;

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    addrDecode #(.ADDR_W(ADDR_W), .LOG0(LOG0), .LOG1(LOG1), .LOG2(LOG2)) u_dec (
      .addr   (hostAddr[gp]),
      .sel    (portSel[gp]),
      .inRange(portInRange[gp]),
      .offset (portOffset[gp])
    );
  end

  arbCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .roundRobin (roundRobin),
    .hostReq    (hostReq),
    .portSel    (portSel),
    .portInRange(portInRange),
    .bankDone   (bankDone),
    .strobe     (strobe),
    .hostWait   (hostWait),
    .hostDone   (hostDone),
    .hostErr    (hostErr)
  );

  arbDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .strobe    (strobe),
    .portOffset(portOffset),
    .bankDone  (bankDone),
    .bankRdata (bankRdata),
    .bankReq   (bankReq),
    .bankAddr  (bankAddr),
    .hostRdata (hostRdata)
  );
endmodule

// File: rtl/flashBankArb_chk.sv
module flashBankArb_chk
  import arbPkg::*;
#(
  parameter int ADDR_W = 26
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NPORT-1:0]              hostReq,
  input logic [NPORT-1:0]              hostWait,
  input logic [NPORT-1:0]              hostDone,
  input logic [NPORT-1:0]              hostErr,
  input logic [NBANK-1:0]              bankReq,
  input logic [NBANK-1:0][ADDR_W-1:0]  bankAddr,
  input logic [NBANK-1:0]              bankDone
);
  for (genvar gb = 0; gb < NBANK; gb++) begin : g_b
    // R6: an open grant keeps its request and address until completion
    a_r6_grant_held: assert property (@(posedge clk) disable iff (!rstN)
      (bankReq[gb] && !bankDone[gb]) |=> (bankReq[gb] && $stable(bankAddr[gb])));
  end

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_p
    a_r3_wait_needs_req: assert property (@(posedge clk) disable iff (!rstN)
      hostWait[gp] |-> hostReq[gp]);
    a_r8_err_completes: assert property (@(posedge clk) disable iff (!rstN)
      hostErr[gp] |-> (hostDone[gp] && !hostWait[gp]));
    a_r7_done_needs_req: assert property (@(posedge clk) disable iff (!rstN)
      hostDone[gp] |-> hostReq[gp]);
  end

  a_r7_done_bounded: assert property (@(posedge clk) disable iff (!rstN)
    $countones(hostDone & ~hostErr) <= $countones(bankDone & bankReq));

  a_r3_grants_bounded: assert property (@(posedge clk) disable iff (!rstN)
    $countones(hostReq & ~hostWait & ~hostErr) <= $countones(bankReq));

  a_r10_idle_no_bank: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq == '0) |-> (bankReq == '0));
endmodule

bind flashBankArb flashBankArb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .hostReq (hostReq),
  .hostWait(hostWait),
  .hostDone(hostDone),
  .hostErr (hostErr),
  .bankReq (bankReq),
  .bankAddr(bankAddr),
  .bankDone(bankDone)
);

// File: tb/flashBankArb_tb.sv
module flashBankArb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic roundRobin = 1'b0;
  logic [1:0] hostReq = '0;
  logic [1:0][AW-1:0] hostAddr = '0;
  logic [1:0] hostWait, hostDone, hostErr;
  logic [1:0][DW-1:0] hostRdata;
  logic [2:0] bankReq;
  logic [2:0][AW-1:0] bankAddr;
  logic [2:0] bankDone;
  logic [2:0][DW-1:0] bankRdata;

  int lat [3] = '{2, 2, 2};
  int cnt [3] = '{0, 0, 0};
  int cyc = 0;
  int doneCyc [2] = '{0, 0};
  int checks = 0;
  int errors = 0;

  typedef struct { logic err; logic [DW-1:0] data; } exp_t;
  exp_t q0 [$];
  exp_t q1 [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flashBankArb u_dut (
    .clk(clk), .rstN(rstN), .roundRobin(roundRobin),
    .hostReq(hostReq), .hostAddr(hostAddr),
    .hostWait(hostWait), .hostDone(hostDone), .hostErr(hostErr), .hostRdata(hostRdata),
    .bankReq(bankReq), .bankAddr(bankAddr), .bankDone(bankDone), .bankRdata(bankRdata)
  );

  // bank model: completes after lat cycles, data = {bank, offset}
  for (genvar b = 0; b < 3; b++) begin : g_bm
    assign bankDone[b]  = bankReq[b] && (cnt[b] == lat[b]);
    assign bankRdata[b] = {8'(b), bankAddr[b][23:0]};
    always @(posedge clk) begin
      if (bankReq[b] && !bankDone[b]) cnt[b] <= cnt[b] + 1;
      else cnt[b] <= 0;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic exp_t expOf(input logic [AW-1:0] a);
    exp_t e;
    e.err = 1'b0;
    if (a < 26'h0400000)      e.data = {8'd0, 24'(a)};
    else if (a < 26'h0C00000) e.data = {8'd1, 24'(a - 26'h0400000)};
    else if (a < 26'h1000000) e.data = {8'd2, 24'(a - 26'h0C00000)};
    else begin e.err = 1'b1; e.data = '0; end
    return e;
  endfunction

  // driver: call just after a rising edge
  task automatic issue(input int p, input logic [AW-1:0] a);
    if (p == 0) q0.push_back(expOf(a)); else q1.push_back(expOf(a));
    hostAddr[p] = a;
    hostReq[p]  = 1'b1;
    do @(negedge clk); while (!hostDone[p]);
    @(posedge clk); #1;
    hostReq[p] = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (rstN && hostDone[p]) begin
        exp_t e;
        doneCyc[p] = cyc;
        if ((p == 0 ? q0.size() : q1.size()) == 0) begin
          chk("R7 unexpected completion", 1, 0);
        end else begin
          e = (p == 0) ? q0.pop_front() : q1.pop_front();
          chk(e.err ? "R8 err flag" : "R7 err flag", 64'(hostErr[p]), 64'(e.err));
          chk(e.err ? "R8 data" : "R1/R7 data", 64'(hostRdata[p]), 64'(e.data));
        end
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    hostReq = '0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
  endtask

  // same-bank conflict, winner finishes at s+2, loser at s+5 (latency 2)
  task automatic conflict(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                          input int win, input string tag);
    int s;
    s = cyc;
    fork
      issue(0, a0);
      issue(1, a1);
      begin
        @(negedge clk);
        chk({tag, " loser waits"}, 64'(hostWait[1-win]), 1);
        chk({tag, " winner no wait"}, 64'(hostWait[win]), 0);
      end
    join
    chk({tag, " winner cycle"}, 64'(doneCyc[win] - s), 2);
    chk({tag, " loser cycle"}, 64'(doneCyc[1-win] - s), 5);
  endtask

  initial begin : main
    int s;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 bankReq", 64'(bankReq), 0);
    chk("R10 done", 64'(hostDone), 0);
    chk("R10 wait", 64'(hostWait), 0);
    chk("R10 err", 64'(hostErr), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 decode boundaries, one port at a time
    issue(0, 26'h03FFFFF);
    issue(1, 26'h0400000);
    issue(0, 26'h0BFFFFF);
    issue(1, 26'h0C00000);
    issue(0, 26'h0FFFFFF);
    s = cyc;
    fork
      issue(1, 26'h0C00010);
      begin
        @(negedge clk);
        chk("R1 bank2 offset", 64'(bankAddr[2]), 64'h10);
        chk("R1 bank2 only", 64'(bankReq), 64'b100);
      end
    join

    // R8 out-of-range
    s = cyc;
    fork
      issue(0, 26'h1000000);
      begin
        @(negedge clk);
        chk("R8 done+err", 64'({hostDone[0], hostErr[0]}), 64'b11);
        chk("R8 no bank access", 64'(bankReq), 0);
      end
    join
    chk("R8 same cycle", 64'(doneCyc[0] - s), 0);

    // R2 different banks in parallel
    s = cyc;
    fork
      issue(0, 26'h0000100);
      issue(1, 26'h0500000);
      begin
        @(negedge clk);
        chk("R2 both banks", 64'(bankReq), 64'b011);
        chk("R2 no wait", 64'(hostWait), 0);
      end
    join
    chk("R2 port0 cycle", 64'(doneCyc[0] - s), 2);
    chk("R2 port1 cycle", 64'(doneCyc[1] - s), 2);

    // R3 / R4 fixed priority conflicts
    conflict(26'h0000040, 26'h0000080, 0, "R4 bank0");
    conflict(26'h0D00000, 26'h0E00000, 0, "R4 bank2");

    // R6 / R9 grant held across a policy change and a higher-priority request
    lat[0] = 4;
    s = cyc;
    fork
      issue(1, 26'h0000200);
      begin
        @(posedge clk); #1;
        roundRobin = 1'b1;
        issue(0, 26'h0000300);
      end
      begin
        @(posedge clk); #1;
        @(negedge clk);
        chk("R6 port0 waits", 64'(hostWait[0]), 1);
        chk("R9 grant kept", 64'(bankAddr[0]), 64'h200);
      end
    join
    chk("R6 owner cycle", 64'(doneCyc[1] - s), 4);
    chk("R6 waiter cycle", 64'(doneCyc[0] - s), 9);
    lat[0] = 2;

    // R5 round-robin from a fresh reset
    roundRobin = 1'b1;
    doReset();
    conflict(26'h0C00100, 26'h0C00200, 0, "R5 reset pointer");
    issue(0, 26'h0400040);
    conflict(26'h0400080, 26'h04000C0, 1, "R5 after port0");
    issue(1, 26'h0400100);
    conflict(26'h0400140, 26'h0400180, 0, "R5 after port1");
    conflict(26'h0000400, 26'h0000500, 0, "R5 bank0 pointer");

    // R4 again after switching back
    roundRobin = 1'b0;
    issue(1, 26'h0400200);
    conflict(26'h0400240, 26'h0400280, 0, "R4 fixed after switch");

    chk("R7 queue0 drained", 64'(q0.size()), 0);
    chk("R7 queue1 drained", 64'(q1.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule